// File: doc/BRIEF.md
# Smart Card Transmit Status Logic

This block keeps the transmit-side status flags of a half-duplex smart card serial link. After each character leaves the shift register, it times a short window in half elementary-time-unit (etu) ticks. In that window it samples the line once for the low error pulse that a receiving card drives back when it rejects a character. The result lands in a sticky error-signal flag. A transmit-end flag reports that the line has gone quiet with nothing left to send. It asserts a fixed delay after the character. The delay depends on the guard mode, and an error pulse or a pending data byte holds it off.

Software reads the flags through a small status port. It clears a flag by writing 0 to that flag's position, and only after a read has returned the flag as 1. Loading the transmit data register, by software or by DMA, clears the data-empty and transmit-end flags together. A low-power stop input returns all flags to their reset values.

Top module: `sc_tx_status`

## Requirements
- R1: With tx_en_i = 1, the line is sampled at the rising edge that takes the 2nd half_tick_i after byte_done_i. If line_i is 0 there, status bit 1 (error-signal flag) is 1 after that edge. If line_i is 1 there, the flag is left unchanged.
- R2: The error-signal flag clears only when a reg_wr_i has reg_wdata_i[1] = 0 and a reg_rd_i seen while the flag was 1 came before it with no other write in between. A write of 1, or a write of 0 with no such read, leaves the flag unchanged.
- R3: Setting tx_en_i to 0 leaves the error-signal flag unchanged. While tx_en_i is 0, the sampler does not set the flag.
- R4: Reset (rst_ni low) and stop_i each put status_o at 3'b001: data empty 1, error 0, transmit end 0.
- R5: When tx_en_i = 0 and the error-signal flag is 0, status bit 2 (transmit end) is 1 after the next edge.
- R6: With guard_i = 0, transmit end sets at the edge that takes the 5th half_tick_i after byte_done_i (2.5 etu), if data empty is 1 and no error signal was seen.
- R7: With guard_i = 1, transmit end sets at the edge that takes the 2nd half_tick_i after byte_done_i (1.0 etu), under the same conditions.
- R8: Transmit end never sets while the error-signal flag is 1. This includes an error detected on the same tick that ends the countdown.
- R9: Status bit 0 (data empty) is set by shift_load_i. It is cleared by data_wr_i, or by a write of reg_wdata_i[0] = 0 that follows a read seeing it as 1. Either clear event also clears transmit end, and a countdown that ends while data empty is 0 does not set transmit end.
- R10: A byte_done_i that arrives while a countdown runs restarts the count from zero.
- R11: status_o is {transmit end, error signal, data empty} in bits 2..0. There is no framing-error flag, and the error-signal flag takes that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Standby or module stop; forces flags to reset values |
| half_tick_i | input | 1 | One-cycle strobe every half etu |
| byte_done_i | input | 1 | One-cycle strobe when a character has been shifted out |
| shift_load_i | input | 1 | Shift register took the data byte; sets data empty |
| line_i | input | 1 | Synchronised data line level |
| tx_en_i | input | 1 | Transmit enable |
| guard_i | input | 1 | Guard mode: 0 gives 2.5 etu, 1 gives 1.0 etu transmit-end delay |
| reg_rd_i | input | 1 | Status read strobe |
| reg_wr_i | input | 1 | Status write strobe |
| reg_wdata_i | input | 2 | Write data: bit 0 data empty, bit 1 error signal |
| data_wr_i | input | 1 | Transmit data register written by software or DMA |
| status_o | output | 3 | {transmit end, error signal, data empty} |

## Verification
A countdown counter that is off by one moves the rising edge of transmit end by one half-etu tick. The stimulus table therefore checks the flag one tick before its due edge and again on that edge, for both guard modes. A lost or stale read-armed bit appears at status_o on the first write that follows: a flag either fails to clear or clears without a read. The directed tests do both orders. An error flag that the enable bit disturbs shows up as soon as transmit end rises on the next edge, because the idle set condition depends on that flag.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  localparam int STAT_W    = 3;
  localparam int WR_W      = 2;
  localparam int EMPTY_BIT = 0;
  localparam int ERR_BIT   = 1;
  localparam int END_BIT   = 2;
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int SAMPLE_AT = 2,
  parameter int END_GM0   = 5,
  parameter int END_GM1   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic tick_i,
  input  logic byte_done_i,
  input  logic guard_i,
  output logic sample_o,
  output logic expire_o
);
  localparam int MAX_T = (END_GM0 > END_GM1) ? END_GM0 : END_GM1;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, target;
  logic             run_q, step;

  always_comb begin
    target   = guard_i ? CNT_W'(END_GM1) : CNT_W'(END_GM0);
    cnt_nxt  = cnt_q + 1'b1;
    step     = run_q && tick_i && !byte_done_i && !stop_i;
    sample_o = step && (cnt_nxt == CNT_W'(SAMPLE_AT));
    expire_o = step && (cnt_nxt >= target);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (byte_done_i) begin
      run_q <= 1'b1;   // restart on every new character
      cnt_q <= '0;
    end else if (step) begin
      if (expire_o) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/sc_err_flag.sv
module sc_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic sample_i,
  input  logic line_i,
  input  logic tx_en_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic err_o,
  output logic set_o
);
  logic err_q, arm_q, clr;

  always_comb begin
    set_o = sample_i && tx_en_i && !line_i;
    clr   = wr_i && !wbit_i && arm_q;
    err_o = err_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (stop_i) begin
      err_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      err_q <= set_o || (err_q && !clr);   // hardware set wins
      if (rd_i && err_q)  arm_q <= 1'b1;
      else if (wr_i)      arm_q <= 1'b0;
      else                arm_q <= arm_q && err_q;
    end
  end
endmodule

// File: rtl/sc_tx_flags.sv
module sc_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic load_i,
  input  logic dwr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic tx_en_i,
  input  logic err_i,
  input  logic err_set_i,
  input  logic expire_i,
  output logic empty_o,
  output logic end_o
);
  logic empty_q, arm_q, end_q, empty_clr;

  always_comb begin
    empty_clr = dwr_i || (wr_i && !wbit_i && arm_q);
    empty_o   = empty_q;
    end_o     = end_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      arm_q   <= 1'b0;
      end_q   <= 1'b0;
    end else if (stop_i) begin
      empty_q <= 1'b1;
      arm_q   <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      if (empty_clr)   empty_q <= 1'b0;
      else if (load_i) empty_q <= 1'b1;

      if (rd_i && empty_q) arm_q <= 1'b1;
      else if (wr_i)       arm_q <= 1'b0;
      else                 arm_q <= arm_q && empty_q;

      if (!tx_en_i && !err_i)
        end_q <= 1'b1;
      else if (empty_clr)
        end_q <= 1'b0;
      else if (expire_i && empty_q && !err_i && !err_set_i)
        end_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sc_tx_status.sv
module sc_tx_status
  import sc_tx_pkg::*;
#(
  parameter int SAMPLE_AT = 2,
  parameter int END_GM0   = 5,
  parameter int END_GM1   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              half_tick_i,
  input  logic              byte_done_i,
  input  logic              shift_load_i,
  input  logic              line_i,
  input  logic              tx_en_i,
  input  logic              guard_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [WR_W-1:0]   reg_wdata_i,
  input  logic              data_wr_i,
  output logic [STAT_W-1:0] status_o
);
  logic sample, expire, err, err_set, empty, tx_end;

  sc_etu_timer #(
    .SAMPLE_AT(SAMPLE_AT), .END_GM0(END_GM0), .END_GM1(END_GM1)
  ) u_timer (
    .clk_i, .rst_ni, .stop_i,
    .tick_i      (half_tick_i),
    .byte_done_i,
    .guard_i,
    .sample_o    (sample),
    .expire_o    (expire)
  );

  sc_err_flag u_err (
    .clk_i, .rst_ni, .stop_i,
    .sample_i (sample),
    .line_i,
    .tx_en_i,
    .rd_i     (reg_rd_i),
    .wr_i     (reg_wr_i),
    .wbit_i   (reg_wdata_i[ERR_BIT]),
    .err_o    (err),
    .set_o    (err_set)
  );

  sc_tx_flags u_flags (
    .clk_i, .rst_ni, .stop_i,
    .load_i    (shift_load_i),
    .dwr_i     (data_wr_i),
    .rd_i      (reg_rd_i),
    .wr_i      (reg_wr_i),
    .wbit_i    (reg_wdata_i[EMPTY_BIT]),
    .tx_en_i,
    .err_i     (err),
    .err_set_i (err_set),
    .expire_i  (expire),
    .empty_o   (empty),
    .end_o     (tx_end)
  );

  always_comb begin
    status_o            = '0;
    status_o[EMPTY_BIT] = empty;
    status_o[ERR_BIT]   = err;
    status_o[END_BIT]   = tx_end;
  end
endmodule

// File: rtl/sc_tx_status_chk.sv
module sc_tx_status_chk
  import sc_tx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              tx_en_i,
  input logic              reg_wr_i,
  input logic              data_wr_i,
  input logic [STAT_W-1:0] status_o
);
  logic err, tx_end;
  assign err    = status_o[ERR_BIT];
  assign tx_end = status_o[END_BIT];

  assert_err_needs_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err) |-> $past(tx_en_i));

  assert_err_clear_by_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err) |-> ($past(reg_wr_i) || $past(stop_i)));

  assert_err_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !reg_wr_i && !stop_i) |=> $stable(err));

  assert_stop_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (status_o == 3'b001));

  assert_end_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !err && !stop_i) |=> tx_end);

  assert_end_holdoff_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_end) |-> !err);

  assert_data_write_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && tx_en_i) |=> !tx_end);
endmodule

bind sc_tx_status sc_tx_status_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stop_i    (stop_i),
  .tx_en_i   (tx_en_i),
  .reg_wr_i  (reg_wr_i),
  .data_wr_i (data_wr_i),
  .status_o  (status_o)
);

// File: tb/sim_sc_tx_status.sv
`timescale 1ns/1ps
module sim_sc_tx_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop = 1'b0, tick = 1'b0, bdone = 1'b0, load = 1'b0, line = 1'b1;
  logic       tx_en = 1'b1, guard = 1'b0, rd = 1'b0, wr = 1'b0, dwr = 1'b0;
  logic [1:0] wdata = 2'b11;
  logic [2:0] status;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  sc_tx_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .stop_i(stop), .half_tick_i(tick),
    .byte_done_i(bdone), .shift_load_i(load), .line_i(line), .tx_en_i(tx_en),
    .guard_i(guard), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .data_wr_i(dwr), .status_o(status)
  );

  // {guard, line, clear_err_first, exp_err, exp_end}
  localparam logic [4:0] VECS [6] = '{
    5'b0_1_1_0_1,
    5'b1_1_1_0_1,
    5'b1_0_1_1_0,
    5'b0_1_0_1_0,
    5'b0_0_1_1_0,
    5'b1_1_1_0_1
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s status act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s bit act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic do_rd();
    rd = 1'b1; step(); rd = 1'b0;
  endtask

  task automatic do_wr(input logic [1:0] v);
    wr = 1'b1; wdata = v; step(); wr = 1'b0; wdata = 2'b11;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1; step(); tick = 1'b0; step();
    end
  endtask

  task automatic pulse_bdone();
    bdone = 1'b1; step(); bdone = 1'b0;
  endtask

  task automatic start_byte();
    dwr = 1'b1;  step(); dwr = 1'b0;
    load = 1'b1; step(); load = 1'b0;
    pulse_bdone();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] v;
    #5;
    chk("R4 reset", status, 3'b001);
    rst_n = 1'b1;
    step();
    chk("R11 layout after reset", status, 3'b001);

    tx_en = 1'b0; step();
    chk("R5 idle end", status, 3'b101);
    tx_en = 1'b1;

    for (int i = 0; i < 6; i++) begin
      v = VECS[i];
      if (v[2]) begin do_rd(); do_wr(2'b01); end
      guard = v[4];
      start_byte();
      line = v[3];
      ticks(v[4] ? 1 : 4);
      chk1($sformatf("R6/R7 vec%0d end before due", i), status[2], 1'b0);
      ticks(1);
      line = 1'b1;
      chk1($sformatf("R1/R8 vec%0d err", i), status[1], v[1]);
      chk1($sformatf("R6/R7/R8 vec%0d end", i), status[2], v[0]);
    end

    // R2: read-then-write-zero clearing
    guard = 1'b1; start_byte(); line = 1'b0; ticks(2); line = 1'b1;
    chk1("R1 err set", status[1], 1'b1);
    do_wr(2'b01);
    chk1("R2 write0 without read", status[1], 1'b1);
    do_rd(); do_wr(2'b11);
    chk1("R2 write1 no effect", status[1], 1'b1);
    do_rd(); do_wr(2'b01);
    chk1("R2 clear after read", status[1], 1'b0);

    // R9: data empty handshake and data write
    start_byte(); ticks(2);
    chk("R7 end set", status, 3'b101);
    do_rd(); do_wr(2'b10);
    chk("R9 empty clear clears end", status, 3'b000);
    load = 1'b1; step(); load = 1'b0;
    chk("R9 load sets empty", status, 3'b001);
    do_wr(2'b10);
    chk("R9 write0 without read", status, 3'b001);
    dwr = 1'b1; step(); dwr = 1'b0;
    pulse_bdone(); ticks(2);
    chk("R9 no end while data pending", status, 3'b000);

    // R10: restart on new character
    guard = 1'b0; start_byte(); ticks(3);
    pulse_bdone(); ticks(4);
    chk1("R10 restart no early end", status[2], 1'b0);
    ticks(1);
    chk1("R10 end after restart", status[2], 1'b1);

    // R3/R8/R5: enable off keeps error, holds end off
    guard = 1'b1; start_byte(); line = 1'b0; ticks(2); line = 1'b1;
    chk("R8 same-tick holdoff", status, 3'b011);
    tx_en = 1'b0; step(); step(); step();
    chk("R3 err kept R8 end held", status, 3'b011);
    do_rd(); do_wr(2'b01);
    chk("R2 clear while disabled", status, 3'b001);
    step();
    chk("R5 end after err clear", status, 3'b101);
    pulse_bdone(); line = 1'b0; ticks(2); line = 1'b1;
    chk("R3 sampler off when disabled", status, 3'b101);
    tx_en = 1'b1;

    // R4: stop
    start_byte(); line = 1'b0; ticks(2); line = 1'b1;
    chk("R1 err before stop", status, 3'b011);
    stop = 1'b1; step(); stop = 1'b0;
    chk("R4 stop clears", status, 3'b001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule